// File: doc/BRIEF.md
# Calibratable One-Second Gate Timer

This block measures out a counting window of nominally one second from the system clock, for use by a frequency counter that tallies input edges while the window is open. The window is made of one short, trimmable leading segment, followed by a programmable delay, followed by a train of identical fixed segments (24 by default). Each segment is a chain of three counters: a prescaler, a compare counter and a postscaler. The leading segment has its own prescale and postscale and takes its compare value from an 8-bit coarse trim. The delay stage adds a fine-trim count of extra clock cycles.

A calibration interface tunes the two trim values. It is active while a calibration level input is held high. A step pulse rotates the adjustment size between fine, medium and coarse, and increment or decrement pulses apply one adjustment. Only one adjustment is accepted per measurement, so each change can be observed on a full window before the next one. When the calibration level drops, a one-cycle save pulse tells the surrounding logic that the current trim outputs may be stored. All pins are plain control and status signals; no streaming data crosses the boundary.

Top module: `onesec_gate`

## Requirements
- R1: After reset, gate_active, gate_done and cal_save are low, step_sel is fine (0), coarse_trim equals COARSE_INIT and fine_delay equals DLY_INIT.
- R2: A start pulse sampled while no window is open makes gate_active high from the next cycle for exactly FIRST_PRE*FIRST_POST*(coarse+1) + delay + N_FIXED*FIX_PRE*FIX_POST*(FIX_CMP+1) cycles. A delay of zero adds no cycles.
- R3: gate_done is high for exactly one cycle: the first cycle after the last active cycle. A start pulse while the window is open is ignored.
- R4: The coarse and delay values used for a window are the ones held in the cycle its start is accepted. Adjustments made while it runs affect only later windows.
- R5: While cal_en is high, each step pulse moves step_sel fine (0) to medium (1) to coarse (2) and back to fine. With cal_en low, step pulses are ignored.
- R6: An accepted adjustment with step_sel coarse moves coarse_trim by one, saturating at 0 and 255. With step_sel fine it moves fine_delay by one, and with step_sel medium by MED_STEP. fine_delay saturates at 0 and 2^DLY_W-1. inc_pls raises the value and dec_pls lowers it.
- R7: At most one adjustment is accepted between two accepted starts, counting from reset. Further pulses, pulses with inc_pls and dec_pls both high, and pulses while cal_en is low leave both trims unchanged.
- R8: A falling edge of cal_en gives a one-cycle cal_save pulse in the following cycle.
- R9: The postscale parameters FIRST_POST and FIX_POST must lie in 1 to 16.

Parameter R9 is a configuration rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that opens a window when idle |
| cal_en | input | 1 | Calibration mode level |
| step_pls | input | 1 | Rotates the adjustment size in calibration mode |
| inc_pls | input | 1 | Raises the selected trim |
| dec_pls | input | 1 | Lowers the selected trim |
| gate_active | output | 1 | High while the counting window is open |
| gate_done | output | 1 | One-cycle pulse after the window closes |
| cal_save | output | 1 | One-cycle pulse after calibration mode is left |
| step_sel | output | 2 | Current adjustment size: 0 fine, 1 medium, 2 coarse |
| coarse_trim | output | 8 | Compare value of the leading segment |
| fine_delay | output | DLY_W | Extra delay cycles after the leading segment |

## Verification
The embedded properties watch, on every cycle, that the done pulse only follows an open window, that the latched trims stay frozen while a window runs, that no second adjustment lands after one was used, that the trims hold outside calibration mode, that the step code never takes its unused value, and that the save pulse follows a falling calibration level. Exact window lengths for different trims, saturation at both trim limits, the zero-delay path and the rotation of the step size depend on whole scenarios. These are shown by the bench's cycle model and its measured window lengths.

// File: rtl/gate_pkg.sv
package gate_pkg;
  typedef enum logic [1:0] {
    STEP_FINE   = 2'd0,
    STEP_MED    = 2'd1,
    STEP_COARSE = 2'd2
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FIRST = 2'd1,
    PH_TRIM  = 2'd2,
    PH_FIXED = 2'd3
  } phase_e;

  localparam int COARSE_W = 8;
endpackage

// File: rtl/gate_segment.sv
// One timed segment: prescaler -> compare counter -> postscaler.
// Length = PRE * POST * (cmp_val + 1) enabled cycles.
module gate_segment #(
  parameter int PRE   = 4,
  parameter int POST  = 15,
  parameter int CMP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CMP_W-1:0] cmp_val,
  output logic             seg_end
);
  localparam int PRE_W  = (PRE  > 1) ? $clog2(PRE)  : 1;
  localparam int POST_W = (POST > 1) ? $clog2(POST) : 1;

  logic [PRE_W-1:0]  pre_cnt;
  logic [CMP_W-1:0]  cmp_cnt;
  logic [POST_W-1:0] post_cnt;
  logic pre_last, cmp_last, post_last;

  assign pre_last  = (pre_cnt  == PRE_W'(PRE - 1));
  assign cmp_last  = (cmp_cnt  == cmp_val);
  assign post_last = (post_cnt == POST_W'(POST - 1));
  assign seg_end   = en && pre_last && cmp_last && post_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      cmp_cnt  <= '0;
      post_cnt <= '0;
    end else if (clr) begin
      pre_cnt  <= '0;
      cmp_cnt  <= '0;
      post_cnt <= '0;
    end else if (en) begin
      pre_cnt <= pre_last ? '0 : pre_cnt + 1'b1;
      if (pre_last)
        cmp_cnt <= cmp_last ? '0 : cmp_cnt + 1'b1;
      if (pre_last && cmp_last)
        post_cnt <= post_last ? '0 : post_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gate_seq.sv
// Window sequencer: leading segment, trim delay, fixed segment train.
module gate_seq
  import gate_pkg::*;
#(
  parameter int FIRST_PRE  = 4,
  parameter int FIRST_POST = 15,
  parameter int FIX_PRE    = 64,
  parameter int FIX_POST   = 16,
  parameter int FIX_CMP    = 240,
  parameter int N_FIXED    = 24,
  parameter int DLY_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [COARSE_W-1:0] coarse,
  input  logic [DLY_W-1:0]    dly,
  output logic                start_acc,
  output logic                gate_active,
  output logic                gate_done
);
  localparam int SEG_W     = (N_FIXED > 1) ? $clog2(N_FIXED) : 1;
  localparam int FIX_CMP_W = (FIX_CMP > 0) ? $clog2(FIX_CMP + 1) : 1;

  phase_e              phase;
  logic [COARSE_W-1:0] c_lat;
  logic [DLY_W-1:0]    d_lat;
  logic [DLY_W-1:0]    trim_cnt;
  logic [SEG_W-1:0]    seg_idx;
  logic                first_end, fix_end;

  assign start_acc   = start && (phase == PH_IDLE);
  assign gate_active = (phase != PH_IDLE);

  gate_segment #(.PRE(FIRST_PRE), .POST(FIRST_POST), .CMP_W(COARSE_W)) u_first (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(phase == PH_FIRST),
    .cmp_val(c_lat), .seg_end(first_end)
  );

  gate_segment #(.PRE(FIX_PRE), .POST(FIX_POST), .CMP_W(FIX_CMP_W)) u_fixed (
    .clk(clk), .rst_n(rst_n), .clr(start_acc), .en(phase == PH_FIXED),
    .cmp_val(FIX_CMP_W'(FIX_CMP)), .seg_end(fix_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      c_lat     <= '0;
      d_lat     <= '0;
      trim_cnt  <= '0;
      seg_idx   <= '0;
      gate_done <= 1'b0;
    end else begin
      gate_done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          phase   <= PH_FIRST;
          c_lat   <= coarse;
          d_lat   <= dly;
          seg_idx <= '0;
        end
        PH_FIRST: if (first_end) begin
          trim_cnt <= '0;
          phase    <= (d_lat == '0) ? PH_FIXED : PH_TRIM;
        end
        PH_TRIM: begin
          if (trim_cnt == d_lat - 1'b1) phase <= PH_FIXED;
          else                          trim_cnt <= trim_cnt + 1'b1;
        end
        PH_FIXED: if (fix_end) begin
          if (seg_idx == SEG_W'(N_FIXED - 1)) begin
            phase     <= PH_IDLE;
            gate_done <= 1'b1;
          end else begin
            seg_idx <= seg_idx + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  a_r3_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    gate_done |-> !gate_active && $past(gate_active));
  a_r4_trims_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(c_lat) && $stable(d_lat));
  a_r2_segment_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= SEG_W'(N_FIXED - 1));
endmodule

// File: rtl/gate_calib.sv
// Calibration controls: step-size rotation, saturating trims, one adjustment per window.
module gate_calib
  import gate_pkg::*;
#(
  parameter int DLY_W       = 16,
  parameter int MED_STEP    = 16,
  parameter int COARSE_INIT = 200,
  parameter int DLY_INIT    = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cal_en,
  input  logic                step_pls,
  input  logic                inc_pls,
  input  logic                dec_pls,
  input  logic                start_acc,
  output step_e               sel,
  output logic [COARSE_W-1:0] coarse,
  output logic [DLY_W-1:0]    dly,
  output logic                cal_save
);
  logic                used, apply, cal_q;
  logic [DLY_W-1:0]    d_step, d_next;
  logic [DLY_W:0]      d_sum;
  logic [COARSE_W-1:0] c_next;

  assign apply  = cal_en && (inc_pls ^ dec_pls) && !used;
  assign d_step = (sel == STEP_MED) ? DLY_W'(MED_STEP) : DLY_W'(1);
  assign d_sum  = {1'b0, dly} + {1'b0, d_step};

  always_comb begin
    if (inc_pls) begin
      d_next = d_sum[DLY_W] ? '1 : d_sum[DLY_W-1:0];
      c_next = (coarse == '1) ? coarse : coarse + 1'b1;
    end else begin
      d_next = (dly < d_step) ? '0 : dly - d_step;
      c_next = (coarse == '0) ? coarse : coarse - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= STEP_FINE;
      coarse   <= COARSE_W'(COARSE_INIT);
      dly      <= DLY_W'(DLY_INIT);
      used     <= 1'b0;
      cal_q    <= 1'b0;
      cal_save <= 1'b0;
    end else begin
      if (apply) begin
        if (sel == STEP_COARSE) coarse <= c_next;
        else                    dly    <= d_next;
      end
      used <= start_acc ? 1'b0 : (used || apply);
      if (cal_en && step_pls) begin
        unique case (sel)
          STEP_FINE: sel <= STEP_MED;
          STEP_MED:  sel <= STEP_COARSE;
          default:   sel <= STEP_FINE;
        endcase
      end
      cal_q    <= cal_en;
      cal_save <= cal_q && !cal_en;
    end
  end

  a_r7_single_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (used && !start_acc) |=> $stable(coarse) && $stable(dly));
  a_r6_hold_outside_cal: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cal_en) |-> $stable(coarse) && $stable(dly));
  a_r5_step_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    sel != 2'd3);
  a_r8_save_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
    cal_save |-> !$past(cal_en) && $past(cal_en, 2));
endmodule

// File: rtl/onesec_gate.sv
module onesec_gate
  import gate_pkg::*;
#(
  parameter int FIRST_PRE   = 4,
  parameter int FIRST_POST  = 15,
  parameter int FIX_PRE     = 64,
  parameter int FIX_POST    = 16,
  parameter int FIX_CMP     = 240,
  parameter int N_FIXED     = 24,
  parameter int DLY_W       = 16,
  parameter int MED_STEP    = 16,
  parameter int COARSE_INIT = 200,
  parameter int DLY_INIT    = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cal_en,
  input  logic                step_pls,
  input  logic                inc_pls,
  input  logic                dec_pls,
  output logic                gate_active,
  output logic                gate_done,
  output logic                cal_save,
  output logic [1:0]          step_sel,
  output logic [COARSE_W-1:0] coarse_trim,
  output logic [DLY_W-1:0]    fine_delay
);
  logic  start_acc;
  step_e sel;

  assign step_sel = sel;

  // R9: postscale range is a configuration rule, checked once.
  initial begin
    a_r9_post_range: assert (FIRST_POST >= 1 && FIRST_POST <= 16 &&
                             FIX_POST >= 1 && FIX_POST <= 16);
  end

  gate_calib #(
    .DLY_W(DLY_W), .MED_STEP(MED_STEP),
    .COARSE_INIT(COARSE_INIT), .DLY_INIT(DLY_INIT)
  ) u_calib (
    .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .step_pls(step_pls),
    .inc_pls(inc_pls), .dec_pls(dec_pls), .start_acc(start_acc),
    .sel(sel), .coarse(coarse_trim), .dly(fine_delay), .cal_save(cal_save)
  );

  gate_seq #(
    .FIRST_PRE(FIRST_PRE), .FIRST_POST(FIRST_POST), .FIX_PRE(FIX_PRE),
    .FIX_POST(FIX_POST), .FIX_CMP(FIX_CMP), .N_FIXED(N_FIXED), .DLY_W(DLY_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .coarse(coarse_trim),
    .dly(fine_delay), .start_acc(start_acc), .gate_active(gate_active),
    .gate_done(gate_done)
  );
endmodule

// File: tb/onesec_gate_tb.sv
`timescale 1ns/1ps
module onesec_gate_tb;
  localparam int FP0 = 2, FQ0 = 2, P1 = 2, Q1 = 2, C1 = 9, NF = 24;
  localparam int DW = 8, MED = 16, CINIT = 253, DINIT = 250;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, cal_en = 0, step_pls = 0, inc_pls = 0, dec_pls = 0;
  logic gate_active, gate_done, cal_save;
  logic [1:0] step_sel;
  logic [7:0] coarse_trim;
  logic [DW-1:0] fine_delay;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  onesec_gate #(
    .FIRST_PRE(FP0), .FIRST_POST(FQ0), .FIX_PRE(P1), .FIX_POST(Q1),
    .FIX_CMP(C1), .N_FIXED(NF), .DLY_W(DW), .MED_STEP(MED),
    .COARSE_INIT(CINIT), .DLY_INIT(DINIT)
  ) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int glen(input int c, input int d);
    return FP0 * FQ0 * (c + 1) + d + NF * P1 * Q1 * (C1 + 1);
  endfunction

  // Behavioural reference model
  bit m_active, m_done, m_used, m_save, m_prev;
  int m_rem, m_coarse, m_dly, m_sel, exp_len;
  int meas_cnt = 0, meas_len = 0;
  bit ap, sa;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; m_done = 0; m_used = 0; m_save = 0; m_prev = 0;
      m_rem = 0; m_coarse = CINIT; m_dly = DINIT; m_sel = 0;
    end else begin
      m_done = 0;
      ap = cal_en && (inc_pls != dec_pls) && !m_used;
      sa = start && !m_active;
      if (m_active) begin
        m_rem--;
        if (m_rem == 0) begin m_active = 0; m_done = 1; end
      end else if (start) begin
        m_active = 1; m_rem = glen(m_coarse, m_dly); exp_len = m_rem;
      end
      if (ap) begin
        if (m_sel == 2) m_coarse = inc_pls ? (m_coarse < 255 ? m_coarse + 1 : 255)
                                           : (m_coarse > 0 ? m_coarse - 1 : 0);
        else begin
          int st;
          st = (m_sel == 1) ? MED : 1;
          m_dly = inc_pls ? ((m_dly + st > DMAX) ? DMAX : m_dly + st)
                          : ((m_dly < st) ? 0 : m_dly - st);
        end
      end
      m_used = sa ? 0 : (m_used || ap);
      if (cal_en && step_pls) m_sel = (m_sel + 1) % 3;
      m_save = m_prev && !cal_en;
      m_prev = cal_en;
    end
    #2;
    if (rst_n) begin
      chk(gate_active == m_active, "R2 gate_active", gate_active, m_active);
      chk(gate_done == m_done, "R3 gate_done", gate_done, m_done);
      chk(coarse_trim == m_coarse, "R6 coarse_trim", coarse_trim, m_coarse);
      chk(fine_delay == m_dly, "R6 fine_delay", fine_delay, m_dly);
      chk(step_sel == m_sel, "R5 step_sel", step_sel, m_sel);
      chk(cal_save == m_save, "R8 cal_save", cal_save, m_save);
      if (gate_active) meas_cnt++;
      if (gate_done) begin meas_len = meas_cnt; meas_cnt = 0; end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic adjust(input bit up);
    @(negedge clk) begin inc_pls = up; dec_pls = !up; end
    @(negedge clk) begin inc_pls = 0; dec_pls = 0; end
  endtask

  task automatic run_gate(input int expect_len);
    pulse(start);
    do @(negedge clk); while (!gate_done);
    chk(meas_len == expect_len, "R2 R4 window length", meas_len, expect_len);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!gate_active && !gate_done && !cal_save, "R1 idle outputs", gate_active, 0);
    chk(coarse_trim == CINIT && fine_delay == DINIT, "R1 trims", coarse_trim, CINIT);
    chk(step_sel == 0, "R1 step_sel", step_sel, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R5: step ignored with cal off; R7: adjust ignored with cal off
    pulse(step_pls); adjust(1);
    chk(step_sel == 0 && fine_delay == DINIT, "R5 R7 ignored when cal off", step_sel, 0);
    // R2/R3: window, with a start during the window ignored
    pulse(start);
    repeat (50) @(negedge clk);
    pulse(start);
    do @(negedge clk); while (!gate_done);
    chk(meas_len == glen(CINIT, DINIT), "R3 restart ignored", meas_len, glen(CINIT, DINIT));
    // R7: one adjust per window, inc+dec ignored
    cal_en = 1;
    adjust(1);
    adjust(1);
    chk(fine_delay == DINIT + 1, "R7 second adjust ignored", fine_delay, DINIT + 1);
    // R4: adjust during window affects only the next
    pulse(start);
    repeat (20) @(negedge clk);
    @(negedge clk) begin inc_pls = 1; dec_pls = 1; end
    @(negedge clk) begin inc_pls = 0; dec_pls = 0; end
    chk(fine_delay == DINIT + 1, "R7 inc and dec together ignored", fine_delay, DINIT + 1);
    pulse(step_pls);
    adjust(1);
    chk(fine_delay == DMAX, "R6 medium saturates high", fine_delay, DMAX);
    do @(negedge clk); while (!gate_done);
    chk(meas_len == glen(CINIT, DINIT + 1), "R4 latched trims", meas_len, glen(CINIT, DINIT + 1));
    // R5 rotate to coarse, R6 coarse saturation at 255
    pulse(step_pls);
    chk(step_sel == 2, "R5 coarse selected", step_sel, 2);
    for (int i = 0; i < 3; i++) begin
      run_gate(glen(coarse_trim, fine_delay));
      adjust(1);
    end
    chk(coarse_trim == 255, "R6 coarse saturates", coarse_trim, 255);
    adjust(0);
    chk(coarse_trim == 255, "R7 extra adjust ignored", coarse_trim, 255);
    run_gate(glen(255, DMAX));
    adjust(0);
    chk(coarse_trim == 254, "R6 coarse down", coarse_trim, 254);
    // back to medium: fine -> medium
    pulse(step_pls); pulse(step_pls);
    chk(step_sel == 1, "R5 wrap to medium", step_sel, 1);
    for (int i = 0; i < 17; i++) begin
      run_gate(glen(coarse_trim, fine_delay));
      adjust(0);
    end
    chk(fine_delay == 0, "R6 delay saturates low", fine_delay, 0);
    run_gate(glen(254, 0));
    // R8 save pulse
    @(negedge clk) cal_en = 0;
    @(negedge clk);
    chk(cal_save == 1, "R8 save pulse", cal_save, 1);
    @(negedge clk);
    chk(cal_save == 0, "R8 save one cycle", cal_save, 0);
    adjust(1);
    chk(fine_delay == 0, "R7 cal off adjust ignored", fine_delay, 0);
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule